// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Write-Through Store Path

This controller sits between a processor port and a memory port that moves one whole line per transfer. It serves byte and word loads and stores. Each line of the cache holds a valid flag, a tag and one line of data. The address splits, from the top bit down, into a tag, a line index and a byte offset. A block can live only in the one line whose index equals the block address modulo the number of lines. When an access lands there, the new block always displaces whatever that line held.

The processor raises `cpu_req` and holds the request stable while `cpu_stall` is high. The access completes on the clock edge at which `cpu_stall` is low. A load that hits finishes in the compare cycle. A load that misses stalls the processor. It then fetches the block over the memory handshake, fills the line, sets its tag and valid flag, and retries the compare, which now hits.

Every store is written through to memory. On a store miss, the parameter `WRITE_ALLOCATE` selects the behaviour:
- **Allocate:** the block is fetched first and the store then updates the cache.
- **No-allocate:** only memory is written and the cache is left untouched.

Top module: `dm_cache_ctrl`

## Requirements
- R1: The address is `{tag, index, offset}` from MSB to LSB. With the defaults these are `addr[11:7]`, `addr[6:3]` and `addr[2:0]`. The memory block address `mem_addr` is `addr[11:3]`, and the line used is the block address modulo `LINES`.
- R2: Reset clears every valid flag, so the first access to any index after reset misses.
- R3: A load hits when the indexed line is valid and its tag equals the address tag. A load hit completes one cycle after the request is first seen, with no memory transfer.
- R4: A load miss keeps `cpu_stall` high and issues one memory read (`mem_we`=0) of the block address. When `mem_ready` is seen, the line is filled and the load completes with the fetched data.
- R5: A fill always overwrites the line at its index. After a conflicting block is brought in, the block it displaced misses again.
- R6: Every store issues exactly one memory write (`mem_we`=1) carrying the stored bytes at their position in the line, with `mem_be` bit k set for each written byte k. The store does not complete before `mem_ready` accepts that write.
- R7: A store that hits updates the cached line, so a later load hits and returns the new bytes.
- R8: With `WRITE_ALLOCATE`=1, a store miss first reads the block, then writes memory, and leaves the line valid with the merged data.
- R9: With `WRITE_ALLOCATE`=0, a store miss writes only memory. The line is unchanged, so a following load of that block misses and fetches the stored value from memory.
- R10: `cpu_size`=0 selects a byte access: the load returns byte `addr[2:0]` of the line zero-extended. `cpu_size`=1 selects a word access: it uses the 4-byte word `addr[2]` (little-endian), and `addr[1:0]` is ignored.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold steady.
- R12: `cpu_stall` is low only in the single completing cycle of a request. It is high again in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until completion |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 1 | 0 = byte, 1 = word |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | WORD_BYTES*8 | Store data (byte stores use bits 7:0) |
| cpu_rdata | output | WORD_BYTES*8 | Load data, valid in the completing cycle |
| cpu_stall | output | 1 | Low only in the cycle an access completes |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write with byte enables, 0 = line read |
| mem_addr | output | ADDR_W-OFFSET bits | Block address |
| mem_wdata | output | LINE_BYTES*8 | Write data placed at its byte lanes |
| mem_be | output | LINE_BYTES | Byte enables of a write |
| mem_ready | input | 1 | Memory accepts the transfer in this cycle |
| mem_rdata | input | LINE_BYTES*8 | Line read data, valid with `mem_ready` |

## Verification
The bench builds two copies of the controller with 16 lines of 8 bytes and a 12-bit address. One copy has `WRITE_ALLOCATE`=1 and the other has `WRITE_ALLOCATE`=0, so both store-miss policies run against the same traffic. The small tag space (random tags drawn from 0 to 3) makes conflict evictions, re-hits and store-then-load sequences frequent. Random memory latency of 0 to 3 cycles keeps the handshake waiting as well as accepting at once.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_COMPARE   = 2'd1,
    ST_REFILL    = 2'd2,
    ST_WRITE_MEM = 2'd3
  } dmc_state_e;

  localparam logic SZ_BYTE = 1'b0;
  localparam logic SZ_WORD = 1'b1;
endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
  parameter int LINES      = 16,
  parameter int TAG_W      = 5,
  parameter int LINE_BYTES = 8,
  localparam int IDX_W     = $clog2(LINES),
  localparam int LINE_BITS = LINE_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      idx,
  output logic                  rd_valid,
  output logic [TAG_W-1:0]      rd_tag,
  output logic [LINE_BITS-1:0]  rd_line,
  input  logic                  fill_en,
  input  logic [TAG_W-1:0]      fill_tag,
  input  logic [LINE_BITS-1:0]  fill_line,
  input  logic                  upd_en,
  input  logic [LINE_BYTES-1:0] upd_be,
  input  logic [LINE_BITS-1:0]  upd_line
);
  logic [LINES-1:0]     valid_q;
  logic [TAG_W-1:0]     tag_q  [LINES];
  logic [LINE_BITS-1:0] data_q [LINES];

  // Only the valid flags need a reset value.
  always_ff @(posedge clk) begin
    if (!rst_n) valid_q <= '0;
    else if (fill_en) valid_q[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[idx]  <= fill_tag;
      data_q[idx] <= fill_line;
    end else if (upd_en) begin
      for (int k = 0; k < LINE_BYTES; k++) begin
        if (upd_be[k]) data_q[idx][k*8 +: 8] <= upd_line[k*8 +: 8];
      end
    end
  end

  assign rd_valid = valid_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_line  = data_q[idx];
endmodule

// File: rtl/dmc_lane.sv
module dmc_lane #(
  parameter int LINE_BYTES = 8,
  parameter int WORD_BYTES = 4,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int WSH       = $clog2(WORD_BYTES),
  localparam int LINE_BITS = LINE_BYTES * 8,
  localparam int WORD_BITS = WORD_BYTES * 8
) (
  input  logic [OFF_W-1:0]      off,
  input  logic                  size,
  input  logic [WORD_BITS-1:0]  wdata,
  input  logic [LINE_BITS-1:0]  line,
  output logic [WORD_BITS-1:0]  rdata,
  output logic [LINE_BYTES-1:0] be,
  output logic [LINE_BITS-1:0]  wline
);
  logic [OFF_W-1:0]     woff;
  logic [WORD_BITS-1:0] word_sel;
  logic [7:0]           byte_sel;

  assign woff     = off >> WSH;
  assign word_sel = line[woff*WORD_BITS +: WORD_BITS];
  assign byte_sel = line[off*8 +: 8];
  assign rdata    = (size == dmc_pkg::SZ_WORD) ? word_sel
                                               : {{(WORD_BITS-8){1'b0}}, byte_sel};

  for (genvar k = 0; k < LINE_BYTES; k++) begin : g_byte
    assign be[k] = (size == dmc_pkg::SZ_WORD) ? (OFF_W'(k / WORD_BYTES) == woff)
                                              : (OFF_W'(k) == off);
    assign wline[k*8 +: 8] = (size == dmc_pkg::SZ_WORD) ? wdata[(k % WORD_BYTES)*8 +: 8]
                                                        : wdata[7:0];
  end
endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm #(
  parameter bit WRITE_ALLOCATE = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cpu_req,
  input  logic                cpu_we,
  input  logic                line_hit,
  input  logic                mem_ready,
  output dmc_pkg::dmc_state_e state,
  output logic                complete,
  output logic                mem_req,
  output logic                mem_we,
  output logic                fill_en,
  output logic                upd_en
);
  import dmc_pkg::*;

  dmc_state_e state_d;
  logic       wr_done_q, wr_done_d;

  always_comb begin
    state_d   = state;
    wr_done_d = wr_done_q;
    complete  = 1'b0;
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    fill_en   = 1'b0;
    upd_en    = 1'b0;
    unique case (state)
      ST_IDLE: if (cpu_req) state_d = ST_COMPARE;
      ST_COMPARE: begin
        if (!cpu_req) begin
          state_d   = ST_IDLE;
          wr_done_d = 1'b0;
        end else if (!cpu_we) begin
          if (line_hit) begin
            complete = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d = ST_REFILL;
          end
        end else if (wr_done_q) begin
          complete  = 1'b1;
          wr_done_d = 1'b0;
          state_d   = ST_IDLE;
        end else if (line_hit || !WRITE_ALLOCATE) begin
          state_d = ST_WRITE_MEM;
        end else begin
          state_d = ST_REFILL;
        end
      end
      ST_REFILL: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          fill_en = 1'b1;
          state_d = ST_COMPARE;
        end
      end
      ST_WRITE_MEM: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ready) begin
          upd_en    = line_hit;
          wr_done_d = 1'b1;
          state_d   = ST_COMPARE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      wr_done_q <= 1'b0;
    end else begin
      state     <= state_d;
      wr_done_q <= wr_done_d;
    end
  end
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl #(
  parameter int ADDR_W         = 12,
  parameter int LINE_BYTES     = 8,
  parameter int LINES          = 16,
  parameter int WORD_BYTES     = 4,
  parameter bit WRITE_ALLOCATE = 1'b1,
  localparam int OFF_W         = $clog2(LINE_BYTES),
  localparam int IDX_W         = $clog2(LINES),
  localparam int TAG_W         = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W         = ADDR_W - OFF_W,
  localparam int LINE_BITS     = LINE_BYTES * 8,
  localparam int WORD_BITS     = WORD_BYTES * 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cpu_req,
  input  logic                  cpu_we,
  input  logic                  cpu_size,
  input  logic [ADDR_W-1:0]     cpu_addr,
  input  logic [WORD_BITS-1:0]  cpu_wdata,
  output logic [WORD_BITS-1:0]  cpu_rdata,
  output logic                  cpu_stall,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [BLK_W-1:0]      mem_addr,
  output logic [LINE_BITS-1:0]  mem_wdata,
  output logic [LINE_BYTES-1:0] mem_be,
  input  logic                  mem_ready,
  input  logic [LINE_BITS-1:0]  mem_rdata
);
  // Address field extraction, MSB to LSB: tag | index | offset.
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] f_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [OFF_W-1:0] f_off(input logic [ADDR_W-1:0] a);
    return a[OFF_W-1:0];
  endfunction
  function automatic logic [BLK_W-1:0] f_blk(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: BLK_W];
  endfunction

  // Named internal events, visible to the bound checker.
  logic                 line_valid;
  logic [TAG_W-1:0]     line_tag;
  logic [LINE_BITS-1:0] line_data;
  logic                 line_hit;
  logic                 complete;
  logic                 fill_fire;
  logic                 upd_fire;
  logic [LINE_BYTES-1:0] lane_be;
  logic [LINE_BITS-1:0]  lane_wline;
  dmc_pkg::dmc_state_e   state;

  dmc_line_store #(
    .LINES     (LINES),
    .TAG_W     (TAG_W),
    .LINE_BYTES(LINE_BYTES)
  ) i_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (f_idx(cpu_addr)),
    .rd_valid (line_valid),
    .rd_tag   (line_tag),
    .rd_line  (line_data),
    .fill_en  (fill_fire),
    .fill_tag (f_tag(cpu_addr)),
    .fill_line(mem_rdata),
    .upd_en   (upd_fire),
    .upd_be   (lane_be),
    .upd_line (lane_wline)
  );

  assign line_hit = line_valid && (line_tag == f_tag(cpu_addr));

  dmc_lane #(
    .LINE_BYTES(LINE_BYTES),
    .WORD_BYTES(WORD_BYTES)
  ) i_lane (
    .off  (f_off(cpu_addr)),
    .size (cpu_size),
    .wdata(cpu_wdata),
    .line (line_data),
    .rdata(cpu_rdata),
    .be   (lane_be),
    .wline(lane_wline)
  );

  dmc_fsm #(
    .WRITE_ALLOCATE(WRITE_ALLOCATE)
  ) i_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_req  (cpu_req),
    .cpu_we   (cpu_we),
    .line_hit (line_hit),
    .mem_ready(mem_ready),
    .state    (state),
    .complete (complete),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .fill_en  (fill_fire),
    .upd_en   (upd_fire)
  );

  assign cpu_stall = !complete;
  assign mem_addr  = f_blk(cpu_addr);
  assign mem_wdata = lane_wline;
  assign mem_be    = mem_we ? lane_be : '0;
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int BLK_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_we,
  input logic             cpu_stall,
  input logic             mem_req,
  input logic             mem_we,
  input logic [BLK_W-1:0] mem_addr,
  input logic             mem_ready,
  input logic             line_hit,
  input logic             complete
);
  // R11: request fields hold until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R3: a completing load makes no memory transfer
  p_hit_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && !cpu_we) |-> !mem_req);

  // R4: an accepted line read leaves the addressed line hitting
  p_fill_hits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ready) |=> line_hit);

  // R6: a store completes right after its memory write was accepted
  p_store_written_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && cpu_we) |-> $past(mem_req && mem_we && mem_ready));

  // R9: a missing store's write leaves the line still missing
  p_miss_write_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ready && !line_hit) |=> !line_hit);

  // R12: the stall drops for one cycle only
  p_single_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_stall |=> cpu_stall);
endmodule

bind dm_cache_ctrl dmc_checker #(.BLK_W(BLK_W)) i_dmc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_we   (cpu_we),
  .cpu_stall(cpu_stall),
  .mem_req  (mem_req),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_ready(mem_ready),
  .line_hit (line_hit),
  .complete (complete)
);

// File: tb/test_dm_cache_ctrl.sv
module dmc_mem_model #(
  parameter int BLK_W      = 9,
  parameter int LINE_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req,
  input  logic                    we,
  input  logic [BLK_W-1:0]        addr,
  input  logic [LINE_BYTES*8-1:0] wdata,
  input  logic [LINE_BYTES-1:0]   be,
  output logic                    ready,
  output logic [LINE_BYTES*8-1:0] rdata,
  output int                      rd_cnt,
  output int                      wr_cnt,
  output int                      viol,
  output logic [BLK_W-1:0]        last_addr
);
  logic [LINE_BYTES*8-1:0] mem [1 << BLK_W];
  int                      wait_q;
  logic                    busy;
  logic [BLK_W-1:0]        held_addr;
  logic                    held_we;

  function automatic logic [63:0] seed_line(input int b);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(b + 1);
  endfunction

  initial for (int i = 0; i < (1 << BLK_W); i++) mem[i] = (LINE_BYTES*8)'(seed_line(i));

  always @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0; wait_q <= 0; busy <= 1'b0;
      rd_cnt <= 0; wr_cnt <= 0; viol <= 0; last_addr <= '0; rdata <= '0;
    end else if (ready) begin
      ready  <= 1'b0;
      busy   <= 1'b0;
      wait_q <= int'($urandom_range(0, 3));
    end else if (req) begin
      if (busy && (addr != held_addr || we != held_we)) viol <= viol + 1;
      busy <= 1'b1; held_addr <= addr; held_we <= we;
      if (wait_q == 0) begin
        ready     <= 1'b1;
        last_addr <= addr;
        if (we) begin
          for (int k = 0; k < LINE_BYTES; k++)
            if (be[k]) mem[addr][k*8 +: 8] <= wdata[k*8 +: 8];
          wr_cnt <= wr_cnt + 1;
        end else begin
          rdata  <= mem[addr];
          rd_cnt <= rd_cnt + 1;
        end
      end else begin
        wait_q <= wait_q - 1;
      end
    end
  end
endmodule

module test_dm_cache_ctrl;
  localparam int ADDR_W = 12;
  localparam int LB     = 8;
  localparam int NL     = 16;
  localparam int BLK_W  = 9;
  localparam int NBLK   = 1 << BLK_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req   [2];
  logic        we    [2];
  logic        size  [2];
  logic [11:0] addr  [2];
  logic [31:0] wdata [2];
  logic [31:0] rdata [2];
  logic        stall [2];
  logic        mreq  [2];
  logic        mwe   [2];
  logic [8:0]  maddr [2];
  logic [63:0] mwdata[2];
  logic [7:0]  mbe   [2];
  logic        mrdy  [2];
  logic [63:0] mrdata[2];
  int          rd_cnt[2];
  int          wr_cnt[2];
  int          viol  [2];
  logic [8:0]  last_a[2];

  logic [63:0] exp_mem [2][NBLK];
  logic        ref_v   [2][NL];
  logic [4:0]  ref_tag [2][NL];

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dm_cache_ctrl #(.WRITE_ALLOCATE(1'b1)) i_dm_cache_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]), .cpu_size(size[0]),
    .cpu_addr(addr[0]), .cpu_wdata(wdata[0]), .cpu_rdata(rdata[0]), .cpu_stall(stall[0]),
    .mem_req(mreq[0]), .mem_we(mwe[0]), .mem_addr(maddr[0]), .mem_wdata(mwdata[0]),
    .mem_be(mbe[0]), .mem_ready(mrdy[0]), .mem_rdata(mrdata[0]));

  dm_cache_ctrl #(.WRITE_ALLOCATE(1'b0)) i_dm_cache_ctrl_nwa (
    .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]), .cpu_size(size[1]),
    .cpu_addr(addr[1]), .cpu_wdata(wdata[1]), .cpu_rdata(rdata[1]), .cpu_stall(stall[1]),
    .mem_req(mreq[1]), .mem_we(mwe[1]), .mem_addr(maddr[1]), .mem_wdata(mwdata[1]),
    .mem_be(mbe[1]), .mem_ready(mrdy[1]), .mem_rdata(mrdata[1]));

  dmc_mem_model #(.BLK_W(BLK_W), .LINE_BYTES(LB)) i_mem0 (
    .clk(clk), .rst_n(rst_n), .req(mreq[0]), .we(mwe[0]), .addr(maddr[0]),
    .wdata(mwdata[0]), .be(mbe[0]), .ready(mrdy[0]), .rdata(mrdata[0]),
    .rd_cnt(rd_cnt[0]), .wr_cnt(wr_cnt[0]), .viol(viol[0]), .last_addr(last_a[0]));

  dmc_mem_model #(.BLK_W(BLK_W), .LINE_BYTES(LB)) i_mem1 (
    .clk(clk), .rst_n(rst_n), .req(mreq[1]), .we(mwe[1]), .addr(maddr[1]),
    .wdata(mwdata[1]), .be(mbe[1]), .ready(mrdy[1]), .rdata(mrdata[1]),
    .rd_cnt(rd_cnt[1]), .wr_cnt(wr_cnt[1]), .viol(viol[1]), .last_addr(last_a[1]));

  function automatic logic [63:0] seed_line(input int b);
    return 64'h9E37_79B9_7F4A_7C15 * 64'(b + 1);
  endfunction
  function automatic logic [11:0] mk(input int t, input int i, input int o);
    return {5'(t), 4'(i), 3'(o)};
  endfunction
  function automatic logic [31:0] pick(input logic [63:0] line, input logic sz, input logic [11:0] a);
    if (sz) return line[a[2]*32 +: 32];
    return {24'd0, line[a[2:0]*8 +: 8]};
  endfunction
  function automatic logic [63:0] merge(input logic [63:0] line, input logic sz,
                                        input logic [11:0] a, input logic [31:0] d);
    logic [63:0] r = line;
    if (sz) r[a[2]*32 +: 32] = d;
    else    r[a[2:0]*8 +: 8] = d[7:0];
    return r;
  endfunction

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // One access on unit u (0 = allocate, 1 = no-allocate), with every check that applies.
  task automatic access(input int u, input logic w, input logic sz,
                        input logic [11:0] a, input logic [31:0] d);
    int          idx = int'(a[6:3]);
    logic [4:0]  tg  = a[11:7];
    int          blk = int'(a[11:3]);
    logic        hit = ref_v[u][idx] && ref_tag[u][idx] == tg;
    int          exp_rd = (!hit && (!w || u == 0)) ? 1 : 0;
    int          exp_wr = w ? 1 : 0;
    int          rd0, wr0, cyc;
    logic [31:0] got;
    @(negedge clk);
    rd0 = rd_cnt[u]; wr0 = wr_cnt[u];
    req[u] = 1'b1; we[u] = w; size[u] = sz; addr[u] = a; wdata[u] = d;
    cyc = 0;
    forever begin
      @(posedge clk); #2;
      cyc++;
      if (!stall[u]) break;
      if (cyc > 60) begin
        chk(1'b0, "R12 watchdog", cyc, 60);
        finish_run();
      end
    end
    got = rdata[u];
    @(posedge clk); #1;
    req[u] = 1'b0;
    #2;
    chk(stall[u] === 1'b1, "R12 stall back high", stall[u], 1);
    chk(rd_cnt[u] - rd0 == exp_rd, w ? (u == 0 ? "R8 reads" : "R9 reads") : "R4 reads",
        rd_cnt[u] - rd0, exp_rd);
    chk(wr_cnt[u] - wr0 == exp_wr, "R6 writes", wr_cnt[u] - wr0, exp_wr);
    if (exp_rd == 1 || w) chk(int'(last_a[u]) == blk, "R1 block address", last_a[u], blk);
    if (!w) begin
      chk(got == pick(exp_mem[u][blk], sz, a), "R10 load data", got, pick(exp_mem[u][blk], sz, a));
      if (hit) chk(cyc == 1, "R3 hit latency", cyc, 1);
    end
    if (w) exp_mem[u][blk] = merge(exp_mem[u][blk], sz, a, d);
    if (!hit && (!w || u == 0)) begin
      ref_v[u][idx] = 1'b1;
      ref_tag[u][idx] = tg;
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "R12 global watchdog", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd2468));
    for (int u = 0; u < 2; u++) begin
      req[u] = 0; we[u] = 0; size[u] = 0; addr[u] = '0; wdata[u] = '0;
      for (int i = 0; i < NBLK; i++) exp_mem[u][i] = seed_line(i);
      for (int i = 0; i < NL; i++) begin ref_v[u][i] = 0; ref_tag[u][i] = '0; end
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    for (int u = 0; u < 2; u++) begin
      chk(stall[u] === 1'b1, "R12 reset stall", stall[u], 1);
      chk(mreq[u] === 1'b0, "R2 reset no mem request", mreq[u], 0);
    end

    // R2, R4, R10: cold byte load misses
    access(0, 0, 0, mk(0, 2, 5), 0);
    // R3, R10: word load in same block hits
    access(0, 0, 1, mk(0, 2, 6), 0);
    // R1, R5: same index, other tag, displaces the line
    access(0, 0, 0, mk(3, 2, 0), 0);
    access(0, 0, 1, mk(0, 2, 0), 0);
    // R6, R7: store hit, then load sees new byte
    access(0, 1, 0, mk(0, 2, 1), 32'h0000_005A);
    access(0, 0, 1, mk(0, 2, 0), 0);
    // R8: allocating store miss, then load hits
    access(0, 1, 1, mk(1, 5, 4), 32'hCAFE_F00D);
    access(0, 0, 1, mk(1, 5, 4), 0);
    // R9: non-allocating store miss, load still misses and sees memory
    access(1, 1, 0, mk(1, 6, 2), 32'h0000_00C3);
    access(1, 0, 1, mk(1, 6, 0), 0);
    // R7 on unit 1: store hit updates the line
    access(1, 1, 1, mk(1, 6, 4), 32'h1234_5678);
    access(1, 0, 1, mk(1, 6, 7), 0);

    for (int n = 0; n < 400; n++) begin
      for (int u = 0; u < 2; u++) begin
        access(u, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 15)), int'($urandom_range(0, 7))),
               $urandom);
      end
    end

    for (int u = 0; u < 2; u++) chk(viol[u] == 0, "R11 request stability", viol[u], 0);
    finish_run();
  end
endmodule